// File: doc/BRIEF.md
# SDRAM Idle Low-Power Entry Controller

This block sits beside an SDRAM memory controller and decides when the memory may drop into a low-power state. Software programs a control word that holds a low-power mode and an idle-timeout exponent. While the command interface is active, the block counts consecutive cycles with no pending request. Once the programmed idle window has passed, it moves the memory into the selected state: self-refresh, clock stop or power-down. It drives the clock-enable line and the clock-gate and power-down hints that go to the physical layer.

When a request arrives during low power, the block first runs a fixed exit sequence and only then grants the request. Software can also force an exit by writing the mode back to off.

The two resets act differently. A cold reset clears the whole configuration. A warm reset keeps the configuration alive: it parks the memory in self-refresh and reloads the live control word from a separately written backup copy.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: The control word is 16 bits, stored whole and read back as written. The mode field is bits 10:8 and the timeout field is bits 7:4. A write with `cfg_wr_shadow`=0 updates the live word, and a read with `cfg_rd_shadow`=0 returns it. A value of 1 on these selects addresses the backup word instead. The read is combinational.
- R2: `lp_status` codes are 0 active, 1 self-refresh, 2 clock stop, 3 power-down and 4 exiting. Consider the active state with effective mode 2, 1 or 4 and timeout field T. Once 2^(T+3) consecutive clock edges have seen `mem_req`=0, the status becomes 1, 2 or 3 respectively.
- R3: `cke` is low only in self-refresh. `mem_clk_en` is low only in clock stop. `phy_pd` is high only in power-down.
- R4: A request seen in any low-power state starts the exit. The status shows 4 (exiting) for EXIT_LAT cycles with `cke` high, then returns to 0. `mem_ack` equals `mem_req` while the status is 0 and is 0 otherwise.
- R5: A cycle with `mem_req`=1 restarts the idle count. Requests spaced closer than the idle window keep the block active.
- R6: Writing the live word with an effective mode of 0 during a low-power state starts the exit sequence at that same edge.
- R7: Mode values 3, 5, 6 and 7 act as mode 0, so the block never enters low power with them. They still read back unchanged.
- R8: A warm reset (`rst_warm_n`=0, `rst_cold_n`=1) copies the backup word into the live word and sets the status to 1. The backup word is left unchanged.
- R9: A cold reset clears both words and sets the status to 0 with `cke` high. A cold reset overrides a warm reset given at the same time.
- R10: `cfg_err` is 1 when the effective mode is 2 and the timeout field is below 9. `cfg_warn` is 1 when the timeout field is below 9 and the effective mode is anything else. Both flags are 0 when the timeout field is 9 or more.
- R11: The backup word changes only on a write with `cfg_wr_shadow`=1 outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Synchronous active-low power-on reset |
| rst_warm_n | input | 1 | Synchronous active-low warm reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_shadow | input | 1 | Write target: 0 live, 1 backup |
| cfg_wdata | input | 16 | Write data |
| cfg_rd_shadow | input | 1 | Read source: 0 live, 1 backup |
| cfg_rdata | output | 16 | Read data |
| mem_req | input | 1 | Pending read or write request |
| mem_ack | output | 1 | Request accepted |
| cke | output | 1 | SDRAM clock enable |
| mem_clk_en | output | 1 | Memory clock gate, low in clock stop |
| phy_pd | output | 1 | Power-down hint, high in power-down |
| lp_status | output | 3 | Current state code |
| cfg_err | output | 1 | Self-refresh with too short an idle window |
| cfg_warn | output | 1 | Too short an idle window in another mode |

## Verification
The hardest situation to reach from the ports is a warm reset that arrives during an exit sequence, or during self-refresh, while the backup word holds a different configuration from the live one. This case is what exposes whether the live word is reloaded or simply cleared. The directed part of the stimulus programs distinct live and backup words and drives a request to start an exit. It then pulses warm reset in the middle of that exit. The random part keeps idle windows short, so that low-power entry, exit and both reset kinds all interleave often, and every cycle is compared against a bench model.

// File: rtl/sdram_lp_pkg.sv
// Package: shared field positions, state codes and mode decode for the
// SDRAM idle low-power controller. Assumes a 16-bit control word.
package sdram_lp_pkg;

    localparam int REG_W    = 16;
    localparam int MODE_LSB = 8;
    localparam int MODE_W   = 3;
    localparam int TMO_LSB  = 4;
    localparam int TMO_W    = 4;

    localparam logic [MODE_W-1:0] MODE_OFF      = 3'd0;
    localparam logic [MODE_W-1:0] MODE_CLK_STOP = 3'd1;
    localparam logic [MODE_W-1:0] MODE_SELF_REF = 3'd2;
    localparam logic [MODE_W-1:0] MODE_PWR_DOWN = 3'd4;

    localparam logic [TMO_W-1:0] TMO_SAFE_MIN = 4'd9;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_SELF_REF = 3'd1,
        ST_CLK_STOP = 3'd2,
        ST_PWR_DOWN = 3'd3,
        ST_EXITING  = 3'd4
    } lp_state_e;

    // Map reserved mode codes onto "off"
    function automatic logic [MODE_W-1:0] eff_mode(input logic [MODE_W-1:0] raw);
        case (raw)
            MODE_CLK_STOP, MODE_SELF_REF, MODE_PWR_DOWN: eff_mode = raw;
            default:                                     eff_mode = MODE_OFF;
        endcase
    endfunction

    // Low-power state that a non-off mode leads to
    function automatic lp_state_e mode_to_state(input logic [MODE_W-1:0] m);
        case (m)
            MODE_SELF_REF: mode_to_state = ST_SELF_REF;
            MODE_CLK_STOP: mode_to_state = ST_CLK_STOP;
            MODE_PWR_DOWN: mode_to_state = ST_PWR_DOWN;
            default:       mode_to_state = ST_ACTIVE;
        endcase
    endfunction

endpackage

// File: rtl/lp_cfg_regs.sv
// Module: live and backup control words with read mux and sanity flags.
// Assumes: cold reset has priority over warm reset; both are synchronous.
// A warm reset reloads the live word from the backup word and blocks writes.
module lp_cfg_regs
    import sdram_lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_cold_n,
    input  logic             rst_warm_n,
    input  logic             wr_en,
    input  logic             wr_shadow,
    input  logic [REG_W-1:0] wdata,
    input  logic             rd_shadow,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] live_q,
    output logic [REG_W-1:0] shadow_q,
    output logic [MODE_W-1:0] mode_eff,
    output logic [TMO_W-1:0] tmo,
    output logic             cfg_err,
    output logic             cfg_warn
);

    logic             short_tmo;
    logic [MODE_W-1:0] mode_raw;

    // Live word: cleared by cold reset, reloaded by warm reset, else written
    always_ff @(posedge clk) begin
        if (!rst_cold_n) begin
            live_q <= '0;
        end else if (!rst_warm_n) begin
            live_q <= shadow_q;
        end else if (wr_en && !wr_shadow) begin
            live_q <= wdata;
        end
    end

    // Backup word: cleared only by cold reset, written only through its select
    always_ff @(posedge clk) begin
        if (!rst_cold_n) begin
            shadow_q <= '0;
        end else if (rst_warm_n && wr_en && wr_shadow) begin
            shadow_q <= wdata;
        end
    end

    // Read mux and field decode
    always_comb begin
        rdata     = rd_shadow ? shadow_q : live_q;
        mode_raw  = live_q[MODE_LSB +: MODE_W];
        mode_eff  = eff_mode(mode_raw);
        tmo       = live_q[TMO_LSB +: TMO_W];
        short_tmo = (tmo < TMO_SAFE_MIN);
        cfg_err   = short_tmo && (mode_eff == MODE_SELF_REF);
        cfg_warn  = short_tmo && (mode_eff != MODE_SELF_REF);
    end

endmodule

// File: rtl/lp_idle_timer.sv
// Module: counts consecutive idle cycles and flags expiry of the window
// 2^(tmo+TMO_OFS). Assumes clear is high whenever counting must not run.
module lp_idle_timer #(
    parameter int TMO_W   = 4,
    parameter int TMO_OFS = 3,
    parameter int CNT_W   = (1 << TMO_W) + TMO_OFS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [TMO_W-1:0] tmo,
    output logic             expired
);

    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] limit;

    // Window length from the timeout exponent
    always_comb begin
        limit   = CNT_W'(1) << (tmo + TMO_OFS);
        expired = !clear && (idle_cnt >= (limit - CNT_W'(1)));
    end

    // Idle counter, saturating at the window length
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idle_cnt <= '0;
        end else if (idle_cnt < limit) begin
            idle_cnt <= idle_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lp_state_fsm.sv
// Module: low-power state machine with exit-latency counter and pin drive.
// Assumes EXIT_LAT >= 1; cold reset parks in active, warm reset in self-refresh.
module lp_state_fsm
    import sdram_lp_pkg::*;
#(
    parameter int EXIT_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_cold_n,
    input  logic              rst_warm_n,
    input  logic [MODE_W-1:0] mode_eff,
    input  logic              expired,
    input  logic              mem_req,
    input  logic              exit_cmd,
    output lp_state_e         state,
    output logic              mem_ack,
    output logic              cke,
    output logic              mem_clk_en,
    output logic              phy_pd
);

    localparam int EXIT_W = $clog2(EXIT_LAT + 1);

    lp_state_e         nxt;
    logic [EXIT_W-1:0] exit_cnt;

    // Next-state selection
    always_comb begin
        nxt = state;
        case (state)
            ST_ACTIVE: begin
                if (expired && (mode_eff != MODE_OFF)) nxt = mode_to_state(mode_eff);
            end
            ST_SELF_REF, ST_CLK_STOP, ST_PWR_DOWN: begin
                if (mem_req || exit_cmd) nxt = ST_EXITING;
            end
            ST_EXITING: begin
                if (exit_cnt == '0) nxt = ST_ACTIVE;
            end
            default: nxt = ST_ACTIVE;
        endcase
    end

    // State register with reset priorities
    always_ff @(posedge clk) begin
        if (!rst_cold_n) begin
            state <= ST_ACTIVE;
        end else if (!rst_warm_n) begin
            state <= ST_SELF_REF;
        end else begin
            state <= nxt;
        end
    end

    // Exit-latency counter, loaded on entry to the exit sequence
    always_ff @(posedge clk) begin
        if (!rst_cold_n || !rst_warm_n) begin
            exit_cnt <= '0;
        end else if (nxt == ST_EXITING && state != ST_EXITING) begin
            exit_cnt <= EXIT_W'(EXIT_LAT - 1);
        end else if (state == ST_EXITING && exit_cnt != '0) begin
            exit_cnt <= exit_cnt - EXIT_W'(1);
        end
    end

    // Output pins decoded from the state
    always_comb begin
        mem_ack    = mem_req && (state == ST_ACTIVE);
        cke        = (state != ST_SELF_REF);
        mem_clk_en = (state != ST_CLK_STOP);
        phy_pd     = (state == ST_PWR_DOWN);
    end

endmodule

// File: rtl/sdram_lp_ctrl.sv
// Module: top of the SDRAM idle low-power controller. Wires the control
// words, the idle timer and the state machine. Assumes synchronous
// active-low resets and a request that stays high until acknowledged.
module sdram_lp_ctrl
    import sdram_lp_pkg::*;
#(
    parameter int EXIT_LAT = 4,
    parameter int TMO_OFS  = 3
) (
    input  logic             clk,
    input  logic             rst_cold_n,
    input  logic             rst_warm_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_wr_shadow,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             cfg_rd_shadow,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             mem_req,
    output logic             mem_ack,
    output logic             cke,
    output logic             mem_clk_en,
    output logic             phy_pd,
    output logic [2:0]       lp_status,
    output logic             cfg_err,
    output logic             cfg_warn
);

    logic [REG_W-1:0]  live_q;
    logic [REG_W-1:0]  shadow_q;
    logic [MODE_W-1:0] mode_eff;
    logic [TMO_W-1:0]  tmo;
    logic              idle_clear;
    logic              expired;
    logic              exit_cmd;
    lp_state_e         state;

    lp_cfg_regs u_cfg (
        .clk        (clk),
        .rst_cold_n (rst_cold_n),
        .rst_warm_n (rst_warm_n),
        .wr_en      (cfg_wr_en),
        .wr_shadow  (cfg_wr_shadow),
        .wdata      (cfg_wdata),
        .rd_shadow  (cfg_rd_shadow),
        .rdata      (cfg_rdata),
        .live_q     (live_q),
        .shadow_q   (shadow_q),
        .mode_eff   (mode_eff),
        .tmo        (tmo),
        .cfg_err    (cfg_err),
        .cfg_warn   (cfg_warn)
    );

    // Idle counting runs only in the active state with no request pending
    always_comb begin
        idle_clear = (state != ST_ACTIVE) || mem_req;
        exit_cmd   = cfg_wr_en && !cfg_wr_shadow &&
                     (eff_mode(cfg_wdata[MODE_LSB +: MODE_W]) == MODE_OFF);
        lp_status  = state;
    end

    lp_idle_timer #(
        .TMO_W   (TMO_W),
        .TMO_OFS (TMO_OFS)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_cold_n && rst_warm_n),
        .clear   (idle_clear),
        .tmo     (tmo),
        .expired (expired)
    );

    lp_state_fsm #(
        .EXIT_LAT (EXIT_LAT)
    ) u_fsm (
        .clk        (clk),
        .rst_cold_n (rst_cold_n),
        .rst_warm_n (rst_warm_n),
        .mode_eff   (mode_eff),
        .expired    (expired),
        .mem_req    (mem_req),
        .exit_cmd   (exit_cmd),
        .state      (state),
        .mem_ack    (mem_ack),
        .cke        (cke),
        .mem_clk_en (mem_clk_en),
        .phy_pd     (phy_pd)
    );

endmodule

// File: rtl/sdram_lp_ctrl_chk.sv
// Module: property checker for sdram_lp_ctrl, bound to the top module.
// Assumes the bound scope provides live_q and shadow_q.
module sdram_lp_ctrl_chk
    import sdram_lp_pkg::*;
#(
    parameter int EXIT_LAT = 4
) (
    input logic             clk,
    input logic             rst_cold_n,
    input logic             rst_warm_n,
    input logic             cfg_wr_en,
    input logic             cfg_wr_shadow,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             mem_ack,
    input logic             cke,
    input logic [2:0]       lp_status,
    input logic             cfg_err,
    input logic             cfg_warn,
    input logic [REG_W-1:0] live_q,
    input logic [REG_W-1:0] shadow_q
);

    int exit_run;

    // Length of the current run of exiting cycles
    always_ff @(posedge clk) begin
        if (!rst_cold_n || lp_status != ST_EXITING) exit_run <= 0;
        else                                         exit_run <= exit_run + 1;
    end

    // R3
    cke_low_only_sr_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !cke |-> lp_status == ST_SELF_REF);

    // R4
    ack_only_active_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        mem_ack |-> lp_status == ST_ACTIVE);

    // R4
    exit_len_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        lp_status == ST_EXITING |-> exit_run < EXIT_LAT);

    // R6
    mode_off_exit_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (rst_warm_n && cfg_wr_en && !cfg_wr_shadow &&
         eff_mode(cfg_wdata[MODE_LSB +: MODE_W]) == MODE_OFF &&
         (lp_status == ST_SELF_REF || lp_status == ST_CLK_STOP || lp_status == ST_PWR_DOWN))
        |=> lp_status == ST_EXITING);

    // R8
    warm_reload_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !rst_warm_n |=> (live_q == $past(shadow_q)) && (lp_status == ST_SELF_REF));

    // R9
    cold_clear_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        $rose(rst_cold_n) |-> (live_q == '0) && (shadow_q == '0) && (lp_status == ST_ACTIVE));

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !(cfg_err && cfg_warn));

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !(cfg_wr_en && cfg_wr_shadow) |=> $stable(shadow_q));

endmodule

bind sdram_lp_ctrl sdram_lp_ctrl_chk #(.EXIT_LAT(EXIT_LAT)) u_chk (
    .clk           (clk),
    .rst_cold_n    (rst_cold_n),
    .rst_warm_n    (rst_warm_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_shadow (cfg_wr_shadow),
    .cfg_wdata     (cfg_wdata),
    .mem_ack       (mem_ack),
    .cke           (cke),
    .lp_status     (lp_status),
    .cfg_err       (cfg_err),
    .cfg_warn      (cfg_warn),
    .live_q        (live_q),
    .shadow_q      (shadow_q)
);

// File: tb/test_sdram_lp_ctrl.sv
// Bench: directed corner cases followed by seeded random traffic, each
// cycle compared against a model built from the requirements.
module test_sdram_lp_ctrl;

    localparam int EXIT_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_cold_n = 1'b0;
    logic        rst_warm_n = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_shadow = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_rd_shadow = 1'b0;
    logic [15:0] cfg_rdata;
    logic        mem_req = 1'b0;
    logic        mem_ack;
    logic        cke;
    logic        mem_clk_en;
    logic        phy_pd;
    logic [2:0]  lp_status;
    logic        cfg_err;
    logic        cfg_warn;

    int checks = 0;
    int errors = 0;

    // Model state
    int m_state = 0;
    int m_live = 0;
    int m_shadow = 0;
    int m_idle = 0;
    int m_exit = 0;

    always #5 clk = ~clk;

    sdram_lp_ctrl #(.EXIT_LAT(EXIT_LAT)) i_sdram_lp_ctrl (
        .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_shadow(cfg_wr_shadow), .cfg_wdata(cfg_wdata),
        .cfg_rd_shadow(cfg_rd_shadow), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_ack(mem_ack), .cke(cke), .mem_clk_en(mem_clk_en),
        .phy_pd(phy_pd), .lp_status(lp_status), .cfg_err(cfg_err), .cfg_warn(cfg_warn)
    );

    function automatic int effm(input int m);
        return (m == 1 || m == 2 || m == 4) ? m : 0;
    endfunction

    function automatic int fmode(input int v);
        return (v >> 8) & 7;
    endfunction

    function automatic int ftmo(input int v);
        return (v >> 4) & 15;
    endfunction

    function automatic int win(input int t);
        return 1 << (t + 3);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model one clock edge from the inputs seen at that edge
    task automatic model_step(input logic c, input logic w, input logic we, input logic ws,
                              input int wd, input logic rq);
        int e;
        int ns;
        int l;
        if (!c) begin
            m_live = 0; m_shadow = 0; m_state = 0; m_idle = 0; m_exit = 0;
        end else if (!w) begin
            m_live = m_shadow; m_state = 1; m_idle = 0; m_exit = 0;
        end else begin
            e  = effm(fmode(m_live));
            l  = win(ftmo(m_live));
            ns = m_state;
            case (m_state)
                0: if (!rq && e != 0 && m_idle + 1 >= l) ns = (e == 2) ? 1 : (e == 1) ? 2 : 3;
                1, 2, 3: if (rq || (we && !ws && effm(fmode(wd)) == 0)) begin
                    ns = 4; m_exit = EXIT_LAT - 1;
                end
                default: if (m_exit == 0) ns = 0; else m_exit--;
            endcase
            if (m_state != 0 || rq) m_idle = 0;
            else if (m_idle < l) m_idle++;
            if (we) begin
                if (ws) m_shadow = wd; else m_live = wd;
            end
            m_state = ns;
        end
    endtask

    // One cycle: drive, compare all outputs with the model, advance the model
    task automatic cyc(input logic c, input logic w, input logic we, input logic ws,
                       input logic [15:0] wd, input logic rq, input logic rs);
        int t;
        @(negedge clk);
        rst_cold_n = c; rst_warm_n = w; cfg_wr_en = we; cfg_wr_shadow = ws;
        cfg_wdata = wd; mem_req = rq; cfg_rd_shadow = rs;
        #1;
        t = ftmo(m_live);
        chk("R2 status", int'(lp_status), m_state);
        chk("R3 cke", int'(cke), int'(m_state != 1));
        chk("R3 clk_en", int'(mem_clk_en), int'(m_state != 2));
        chk("R3 pd", int'(phy_pd), int'(m_state == 3));
        chk("R4 ack", int'(mem_ack), int'(rq && m_state == 0));
        chk("R1 rdata", int'(cfg_rdata), rs ? m_shadow : m_live);
        chk("R10 err", int'(cfg_err), int'(t < 9 && effm(fmode(m_live)) == 2));
        chk("R10 warn", int'(cfg_warn), int'(t < 9 && effm(fmode(m_live)) != 2));
        @(posedge clk);
        #1;
        model_step(c, w, we, ws, int'(wd), rq);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 16'h0, 0, 0);
    endtask

    task automatic run_all();
        logic [15:0] wd;
        // R9: cold reset state
        cyc(0, 1, 0, 0, 16'h0, 0, 0);
        cyc(0, 1, 0, 0, 16'h0, 0, 1);
        chk("R9 status", int'(lp_status), 0);
        chk("R9 cke", int'(cke), 1);
        chk("R9 shadow", int'(cfg_rdata), 0);
        // R2: self-refresh entry after 8 idle edges
        cyc(1, 1, 1, 0, 16'h0200, 0, 0);
        idle(10);
        chk("R2 entry", int'(lp_status), 1);
        chk("R3 cke low", int'(cke), 0);
        // R4: exit sequence
        cyc(1, 1, 0, 0, 16'h0, 1, 0);
        chk("R4 exiting", int'(lp_status), 4);
        chk("R4 cke high", int'(cke), 1);
        for (int i = 0; i < EXIT_LAT; i++) cyc(1, 1, 0, 0, 16'h0, 1, 0);
        chk("R4 back", int'(lp_status), 0);
        cyc(1, 1, 0, 0, 16'h0, 0, 0);
        // R5: requests every 6th cycle keep the block active
        for (int k = 0; k < 6; k++) begin
            idle(5);
            cyc(1, 1, 0, 0, 16'h0, 1, 0);
        end
        chk("R5 active", int'(lp_status), 0);
        // R6: writing mode off forces an exit
        idle(10);
        cyc(1, 1, 1, 0, 16'h0000, 0, 0);
        chk("R6 exit", int'(lp_status), 4);
        idle(4);
        // R7: reserved mode never enters
        cyc(1, 1, 1, 0, 16'h0300, 0, 0);
        idle(20);
        chk("R7 active", int'(lp_status), 0);
        cyc(1, 1, 0, 0, 16'h0, 0, 0);
        chk("R7 readback", int'(cfg_rdata), 16'h0300);
        // R11: backup write leaves the live word alone
        cyc(1, 1, 1, 1, 16'h02A0, 0, 0);
        chk("R11 live", int'(cfg_rdata), 16'h0300);
        cyc(1, 1, 0, 0, 16'h0, 0, 1);
        chk("R11 shadow", int'(cfg_rdata), 16'h02A0);
        // R8: warm reset reloads and parks in self-refresh
        cyc(1, 0, 0, 0, 16'h0, 0, 0);
        chk("R8 status", int'(lp_status), 1);
        chk("R8 live", int'(cfg_rdata), 16'h02A0);
        cyc(1, 1, 0, 0, 16'h0, 0, 1);
        chk("R8 shadow", int'(cfg_rdata), 16'h02A0);
        // R8: warm reset in the middle of an exit
        cyc(1, 1, 0, 0, 16'h0, 1, 0);
        cyc(1, 0, 0, 0, 16'h0, 1, 0);
        chk("R8 mid-exit", int'(lp_status), 1);
        for (int i = 0; i < EXIT_LAT + 1; i++) cyc(1, 1, 0, 0, 16'h0, 1, 0);
        cyc(1, 1, 0, 0, 16'h0, 0, 0);
        // R10: flags
        cyc(1, 1, 1, 0, 16'h0230, 1, 0);
        chk("R10 err", int'(cfg_err), 1);
        cyc(1, 1, 1, 0, 16'h0130, 1, 0);
        chk("R10 warn", int'(cfg_warn), 1);
        cyc(1, 1, 1, 0, 16'h0290, 1, 0);
        chk("R10 none", int'(cfg_err | cfg_warn), 0);
        // R9: cold overrides warm
        cyc(0, 0, 0, 0, 16'h0, 0, 0);
        chk("R9 cold wins", int'(lp_status), 0);
        chk("R9 live", int'(cfg_rdata), 0);
        // Random phase
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r;
            int md;
            int tm;
            r  = $urandom % 1000;
            md = $urandom % 8;
            tm = ($urandom % 8 == 0) ? 9 + ($urandom % 7) : $urandom % 3;
            wd = 16'($urandom);
            wd[10:8] = 3'(md);
            wd[7:4]  = 4'(tm);
            cyc(r >= 3, r >= 10 || r < 3, ($urandom % 20) == 0, ($urandom % 3) == 0, wd,
                ($urandom % 8) == 0, ($urandom % 2) == 1);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule